// File: doc/BRIEF.md
# Flash Programming Control Register

This block is a single special-function register that controls how an 8-bit microcontroller may modify its on-chip program flash. It decodes the processor's register-file port at one fixed address. It holds a program-write-enable bit, a mass-erase arm bit and a security latch. It also reflects a live preboot status input on reads.

The program-write-enable bit drives a steering output. While that output is high, external-data move cycles are directed into program flash instead of data RAM. Hardware clears the bit after every programmed byte. The bit cannot be changed while interrupts are globally enabled.

The erase arm is consumed by the first erase it launches. The security latch can only be set, and it is cleared only by reset. Its value is exported directly as a block on external flash reads. The flash timing, the erase engine and the processor core sit outside this block.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, the write-enable, erase-arm and security bits are 0, and `movx_to_flash`, `mass_erase_start` and `read_block` are all low.
- R2: A write with `sfr_addr` = 0xB2 while `irq_global_en` is 0 loads `sfr_wr_data[0]` into the write-enable bit. `movx_to_flash` shows the new value from the next clock edge.
- R3: While `irq_global_en` is 1, a write to 0xB2 leaves the write-enable bit unchanged.
- R4: A `flash_byte_done` pulse clears the write-enable bit at the next edge. It wins over a write to 0xB2 in the same cycle.
- R5: A write to 0xB2 loads `sfr_wr_data[1]` into the erase arm, whatever the state of `irq_global_en`. `mass_erase_start` is high in any cycle where the arm is set and `erase_trigger` is high. That same edge clears the arm, even if a write is present in the same cycle.
- R6: An `erase_trigger` while the arm is clear produces no `mass_erase_start`.
- R7: A write to 0xB2 with `sfr_wr_data[6]` = 1 sets the security bit. A write with that bit at 0 leaves the security bit unchanged, and only reset clears it. `read_block` equals the security bit.
- R8: Reading at 0xB2 returns the write-enable bit at bit 0, the security bit at bit 6 and the live `preboot_active` level at bit 7. Bits 1 to 5 read 0, and the erase arm is never readable.
- R9: Reads and writes at any address other than 0xB2 change no state, and `sfr_rd_data` is 0 for those addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sfr_addr | input | 8 | Register-file address |
| sfr_wr_en | input | 1 | Register-file write strobe |
| sfr_wr_data | input | 8 | Register-file write data |
| sfr_rd_data | output | 8 | Register-file read data; combinational from the address |
| irq_global_en | input | 1 | Global interrupt enable state of the processor |
| flash_byte_done | input | 1 | One-cycle pulse when a byte has been written to flash |
| erase_trigger | input | 1 | Request to launch a mass erase |
| preboot_active | input | 1 | High while the preboot sequence runs |
| movx_to_flash | output | 1 | Steers external-data moves to program flash when high |
| mass_erase_start | output | 1 | Erase launch; high when armed and triggered |
| read_block | output | 1 | Blocks external reads of flash and engine program RAM |

## Verification
The properties assume that `rst_n` is the only way state is cleared. They also assume the strobe inputs are sampled on the rising edge with no glitch between edges. The stimulus drives every input only on the falling edge. Random traffic mixes writes inside and outside the register address with random interrupt, byte-done and trigger levels. Directed sequences cover the collisions: byte-done against a write, trigger against a re-arming write, and an attempt to clear the security latch. The directed sequences only start after the internal reset release has completed.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_WREN = 0;
  localparam int BIT_ARM  = 1;
  localparam int BIT_SEC  = 6;
  localparam int BIT_BOOT = 7;

  typedef struct packed {
    logic hit_wr;
    logic wren_d;
    logic arm_d;
    logic sec_d;
  } fpc_wr_t;
endpackage

// File: rtl/fpc_sfr_port.sv
module fpc_sfr_port
  import fpc_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'hB2
) (
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [DATA_W-1:0] sfr_wr_data,
  input  logic              wren_q,
  input  logic              sec_q,
  input  logic              preboot_active,
  output fpc_wr_t           wr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  logic hit;
  logic unused_wr_bits;

  assign hit            = (sfr_addr == MATCH);
  assign unused_wr_bits = ^{sfr_wr_data[5:2]};

  always_comb begin
    wr.hit_wr = hit & sfr_wr_en;
    wr.wren_d = sfr_wr_data[BIT_WREN];
    wr.arm_d  = sfr_wr_data[BIT_ARM];
    wr.sec_d  = sfr_wr_data[BIT_SEC];
  end

  always_comb begin
    rd_data = '0;
    if (hit) begin
      rd_data[BIT_WREN] = wren_q;
      rd_data[BIT_SEC]  = sec_q;
      rd_data[BIT_BOOT] = preboot_active;
    end
  end
endmodule

// File: rtl/fpc_wren.sv
module fpc_wren (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic wr_bit,
  input  logic irq_global_en,
  input  logic flash_byte_done,
  output logic wren_q
);
  logic wren_d;
  logic wren_ld;

  always_comb begin
    wren_d  = wren_q;
    wren_ld = 1'b0;
    if (flash_byte_done) begin
      wren_d  = 1'b0;
      wren_ld = 1'b1;
    end else if (hit_wr && !irq_global_en) begin
      wren_d  = wr_bit;
      wren_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wren_q <= 1'b0;
    else if (wren_ld) wren_q <= wren_d;
  end
endmodule

// File: rtl/fpc_erase_arm.sv
module fpc_erase_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic wr_bit,
  input  logic erase_trigger,
  output logic erase_go
);
  logic arm_q;
  logic arm_d;
  logic arm_ld;

  assign erase_go = arm_q & erase_trigger;

  always_comb begin
    arm_d  = arm_q;
    arm_ld = 1'b0;
    if (erase_go) begin
      arm_d  = 1'b0;
      arm_ld = 1'b1;
    end else if (hit_wr) begin
      arm_d  = wr_bit;
      arm_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_ld) arm_q <= arm_d;
  end
endmodule

// File: rtl/fpc_secure.sv
module fpc_secure (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_wr,
  input  logic wr_bit,
  output logic sec_q
);
  logic sec_set;

  assign sec_set = hit_wr & wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sec_q <= 1'b0;
    else if (sec_set) sec_q <= 1'b1;
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] REG_ADDR    = 8'hB2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr_en,
  input  logic [7:0]        sfr_wr_data,
  output logic [7:0]        sfr_rd_data,
  input  logic              irq_global_en,
  input  logic              flash_byte_done,
  input  logic              erase_trigger,
  input  logic              preboot_active,
  output logic              movx_to_flash,
  output logic              mass_erase_start,
  output logic              read_block
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int_n;
  fpc_wr_t           wr;
  logic              wren_q;
  logic              sec_q;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_sync_q <= '0;
        else        rst_sync_q <= '1;
      end
    end
  endgenerate

  assign rst_int_n = rst_sync_q[SYNC_MSB];

  fpc_sfr_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
    .sfr_addr       (sfr_addr),
    .sfr_wr_en      (sfr_wr_en),
    .sfr_wr_data    (sfr_wr_data),
    .wren_q         (wren_q),
    .sec_q          (sec_q),
    .preboot_active (preboot_active),
    .wr             (wr),
    .rd_data        (sfr_rd_data)
  );

  fpc_wren u_wren (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .hit_wr          (wr.hit_wr),
    .wr_bit          (wr.wren_d),
    .irq_global_en   (irq_global_en),
    .flash_byte_done (flash_byte_done),
    .wren_q          (wren_q)
  );

  fpc_erase_arm u_arm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .hit_wr        (wr.hit_wr),
    .wr_bit        (wr.arm_d),
    .erase_trigger (erase_trigger),
    .erase_go      (mass_erase_start)
  );

  fpc_secure u_sec (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hit_wr (wr.hit_wr),
    .wr_bit (wr.sec_d),
    .sec_q  (sec_q)
  );

  assign movx_to_flash = wren_q;
  assign read_block    = sec_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'hB2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_rd_data,
  input logic              irq_global_en,
  input logic              flash_byte_done,
  input logic              erase_trigger,
  input logic              preboot_active,
  input logic              movx_to_flash,
  input logic              mass_erase_start,
  input logic              read_block
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  AST_WREN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_global_en && !flash_byte_done) |=> $stable(movx_to_flash)); // R3

  AST_WREN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flash_byte_done |=> !movx_to_flash); // R4

  AST_ERASE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_start |=> !mass_erase_start); // R5

  AST_ERASE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_trigger |-> !mass_erase_start); // R6

  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    read_block |=> read_block); // R7

  AST_READ_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == MATCH) |-> (sfr_rd_data[7] == preboot_active && sfr_rd_data[5:1] == 5'd0)); // R8

  AST_READ_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr != MATCH) |-> (sfr_rd_data == 8'd0)); // R9
endmodule

bind flash_prog_ctrl fpc_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .sfr_addr         (sfr_addr),
  .sfr_rd_data      (sfr_rd_data),
  .irq_global_en    (irq_global_en),
  .flash_byte_done  (flash_byte_done),
  .erase_trigger    (erase_trigger),
  .preboot_active   (preboot_active),
  .movx_to_flash    (movx_to_flash),
  .mass_erase_start (mass_erase_start),
  .read_block       (read_block)
);

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;
  localparam logic [7:0] REG = 8'hB2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic       sfr_wr_en;
  logic [7:0] sfr_wr_data;
  logic [7:0] sfr_rd_data;
  logic       irq_global_en;
  logic       flash_byte_done;
  logic       erase_trigger;
  logic       preboot_active;
  logic       movx_to_flash;
  logic       mass_erase_start;
  logic       read_block;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;
  logic m_wren, m_arm, m_sec;

  always #2 clk = ~clk;

  flash_prog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr_en(sfr_wr_en),
    .sfr_wr_data(sfr_wr_data), .sfr_rd_data(sfr_rd_data),
    .irq_global_en(irq_global_en), .flash_byte_done(flash_byte_done),
    .erase_trigger(erase_trigger), .preboot_active(preboot_active),
    .movx_to_flash(movx_to_flash), .mass_erase_start(mass_erase_start),
    .read_block(read_block)
  );

  function automatic logic nx_wren(logic cur, logic hw, logic irq, logic done, logic d);
    if (done) return 1'b0;
    if (hw && !irq) return d;
    return cur;
  endfunction

  function automatic logic nx_arm(logic cur, logic hw, logic trig, logic d);
    if (cur && trig) return 1'b0;
    if (hw) return d;
    return cur;
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a, logic w, logic s, logic p);
    if (a != REG) return 8'h00;
    return {p, s, 5'b0, w};
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check combinational and state outputs, update model at posedge.
  task automatic cyc(logic [7:0] a, logic we, logic [7:0] d, logic irq,
                     logic done, logic trig, logic pre);
    @(negedge clk);
    sfr_addr = a; sfr_wr_en = we; sfr_wr_data = d; irq_global_en = irq;
    flash_byte_done = done; erase_trigger = trig; preboot_active = pre;
    #1;
    check(movx_to_flash == m_wren, "R2", {7'b0, movx_to_flash}, {7'b0, m_wren});
    check(mass_erase_start == (m_arm & trig), "R5", {7'b0, mass_erase_start}, {7'b0, m_arm & trig});
    check(read_block == m_sec, "R7", {7'b0, read_block}, {7'b0, m_sec});
    if (a == REG)
      check(sfr_rd_data == exp_rd(a, m_wren, m_sec, pre), "R8", sfr_rd_data, exp_rd(a, m_wren, m_sec, pre));
    else
      check(sfr_rd_data == 8'h00, "R9", sfr_rd_data, 8'h00);
    @(posedge clk);
    m_wren = nx_wren(m_wren, we && a == REG, irq, done, d[0]);
    m_arm  = nx_arm(m_arm, we && a == REG, trig, d[1]);
    m_sec  = m_sec | (we && a == REG && d[6]);
  endtask

  task automatic idle();
    cyc(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_0B2;
    void'($urandom(seed));
    m_wren = 1'b0; m_arm = 1'b0; m_sec = 1'b0;
    rst_n = 1'b0; sfr_addr = REG; sfr_wr_en = 1'b0; sfr_wr_data = 8'h00;
    irq_global_en = 1'b0; flash_byte_done = 1'b0; erase_trigger = 1'b1; preboot_active = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!movx_to_flash && !mass_erase_start && !read_block, "R1",
          {5'b0, movx_to_flash, mass_erase_start, read_block}, 8'h00);
    check(sfr_rd_data == 8'h00, "R1", sfr_rd_data, 8'h00);
    rst_n = 1'b1;
    erase_trigger = 1'b0;
    repeat (4) idle();

    // R2: load write enable with interrupts off
    cyc(REG, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 check(movx_to_flash == 1'b1, "R2", {7'b0, movx_to_flash}, 8'h01);
    // R4: byte done beats a simultaneous write
    cyc(REG, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    #1 check(movx_to_flash == 1'b0, "R4", {7'b0, movx_to_flash}, 8'h00);
    // R3: locked while interrupts are enabled
    cyc(REG, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 check(movx_to_flash == 1'b0, "R3", {7'b0, movx_to_flash}, 8'h00);
    cyc(REG, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(REG, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 check(movx_to_flash == 1'b1, "R3", {7'b0, movx_to_flash}, 8'h01);
    cyc(REG, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

    // R6: trigger without arm
    cyc(REG, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); erase_trigger = 1'b1; #1;
    check(mass_erase_start == 1'b0, "R6", {7'b0, mass_erase_start}, 8'h00);
    erase_trigger = 1'b0;
    // R5: arm with interrupts on, fire, re-arm write loses to the fire
    cyc(REG, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(REG, 1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); erase_trigger = 1'b1; sfr_wr_en = 1'b0; #1;
    check(mass_erase_start == 1'b0, "R5", {7'b0, mass_erase_start}, 8'h00);
    erase_trigger = 1'b0;
    // R8: arm not readable, preboot live
    cyc(REG, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); sfr_wr_en = 1'b0; preboot_active = 1'b1; #1;
    check(sfr_rd_data == 8'h80, "R8", sfr_rd_data, 8'h80);
    cyc(REG, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: write elsewhere ignored
    cyc(8'hB3, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); sfr_addr = REG; sfr_wr_en = 1'b0; #1;
    check(sfr_rd_data == 8'h00, "R9", sfr_rd_data, 8'h00);

    // random traffic before security is set
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      logic [7:0] d;
      a = ($urandom % 4 != 0) ? REG : 8'($urandom);
      d = 8'($urandom) & 8'hBF;
      cyc(a, ($urandom % 5) < 2, d, $urandom % 2, ($urandom % 5) == 0,
          ($urandom % 5) == 0, $urandom % 2);
    end

    // R7: set security, then try to clear it
    cyc(REG, 1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(REG, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); sfr_wr_en = 1'b0; #1;
    check(read_block == 1'b1, "R7", {7'b0, read_block}, 8'h01);

    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 != 0) ? REG : 8'($urandom);
      cyc(a, ($urandom % 5) < 2, 8'($urandom), $urandom % 2, ($urandom % 5) == 0,
          ($urandom % 5) == 0, $urandom % 2);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule